// File: doc/BRIEF.md
# CAN Bus Integration Idle Detector

This block decides when a CAN node has seen enough quiet bus time to join traffic. After a start request it enters an integration phase and, at every bit sample point, counts consecutive recessive bits. When the count reaches eleven, the node is declared synchronized. The block then drops its integrating flag, emits a one-clock completion pulse and holds a bus-idle flag until the next entry or reset.

An optional edge filter can be armed for the integration phase. While it is active, a dominant level must last for two consecutive time quanta before it restarts the count, so a one-quantum dominant spike is ignored. The filter turns itself off when integration completes. A falling edge that arrives in the quantum just before the completing sample point is still reported as a start-of-frame sync edge together with the completion pulse. It is not lost to the filter delay.

The receive line is expected to be already synchronized to `clk`. Both `tq_tick` and `sp_tick` are single-clock strobes that come from an external bit-timing unit. The block has no data stream, so all of its pins are plain control and status signals.

Top module: `canbus_idle_integrator`

## Requirements
- R1: While `rst_n` is low, and after reset until an entry condition occurs, `integrating`, `bus_idle`, `integ_done` and `sof_edge` are 0 and the recessive-bit count is zero.
- R2: A 1-to-0 change of `init_ctl` starts integration: `integrating` is 1 from the clock after the change, and the count starts from zero.
- R3: A `pex_pulse` with `init_ctl` at 0 starts or restarts integration (count cleared, `bus_idle` cleared) one clock later when `pex_dis` is 0. When `pex_dis` is 1, the pulse has no effect.
- R4: While `init_ctl` is 1, all four outputs are 0 from the next clock and the count is cleared, aborting any integration in progress.
- R5: Integration completes at the sample point of the 11th consecutive recessive bit. One clock later `integ_done` is 1 for exactly one clock, `integrating` falls, and `bus_idle` rises and stays 1 until the next entry, abort or reset.
- R6: With the filter off, a dominant level (`rx_line` = 0; 1 is recessive) present at a sample point clears the count. Dominant quanta between sample points have no effect on the count.
- R7: With the filter on, the count is cleared at the next sample point only after `rx_line` was 0 at two consecutive `tq_tick`s, including two quanta that straddle a bit boundary. A single dominant quantum is ignored, even one that covers the sample point.
- R8: The value of `efilt_en` is captured at each integration entry. Changes to it during integration take effect only at the next entry.
- R9: The filter is never active outside integration. While `bus_idle` is 1, each 1-to-0 change of `rx_line` gives a one-clock `sof_edge` pulse on the following clock.
- R10: During integration, `sof_edge` pulses one clock after a raw falling edge when the filter is off. When the filter is on, it pulses once, one clock after the `tq_tick` that confirms the second dominant quantum.
- R11: With the filter on, a falling edge of `rx_line` within the quantum ending at the completing sample point produces `sof_edge` in the same clock as `integ_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_line | input | 1 | Synchronized receive level, 1 = recessive, 0 = dominant |
| tq_tick | input | 1 | One-clock strobe at each time quantum |
| sp_tick | input | 1 | One-clock strobe at each bit sample point |
| init_ctl | input | 1 | Initialization request; 1 holds the block idle, a fall starts integration |
| pex_pulse | input | 1 | Protocol exception event, one clock |
| pex_dis | input | 1 | 1 blocks re-integration on a protocol exception |
| efilt_en | input | 1 | Edge filter request, captured at integration entry |
| integrating | output | 1 | Integration phase in progress |
| integ_done | output | 1 | One-clock pulse when integration completes |
| bus_idle | output | 1 | Node synchronized; bus seen idle |
| sof_edge | output | 1 | Hard-sync (start-of-frame) edge indication, one clock |

## Verification
The bench uses the default parameters: eleven idle bits, a 4-bit derived count and a two-quantum filter. It drives four quanta per bit, with the sample point at the end of the third quantum. This setting allows a full sweep of dominant-bit positions against every count value from 0 to 10. It also allows every single-quantum spike position within a bit, filter runs of one to three quanta, and a run that straddles a bit boundary. The short bit also lets the bench place an edge in the final quantum before completion, where the filtered and unfiltered outcomes differ by a whole restart.

// File: rtl/canint_pkg.sv
package canint_pkg;

  typedef enum logic [1:0] {
    PH_OFF   = 2'd0,
    PH_INTEG = 2'd1,
    PH_IDLE  = 2'd2
  } phase_e;

  // Phase successor: abort beats entry, entry beats completion.
  function automatic phase_e phase_step(phase_e cur, logic abort, logic enter, logic finish);
    phase_e nxt;
    nxt = cur;
    if (abort)       nxt = PH_OFF;
    else if (enter)  nxt = PH_INTEG;
    else if (finish) nxt = PH_IDLE;
    return nxt;
  endfunction

endpackage

// File: rtl/canint_entry.sv
module canint_entry (
  input  logic clk,
  input  logic rst_n,
  input  logic init_ctl,
  input  logic pex_pulse,
  input  logic pex_dis,
  output logic enter,
  output logic abort
);
  logic init_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) init_q <= 1'b1;
    else        init_q <= init_ctl;
  end

  assign abort = init_ctl;
  assign enter = !init_ctl && (init_q || (pex_pulse && !pex_dis));
endmodule

// File: rtl/canint_edge_filter.sv
module canint_edge_filter #(
  parameter int FILT_TQ = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic clear,
  input  logic rx,
  input  logic tq_tick,
  input  logic sp_tick,
  output logic raw_fall,
  output logic dom_hit,
  output logic filt_edge,
  output logic edge_pend
);
  localparam int RUN_W = $clog2(FILT_TQ + 1);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(FILT_TQ);
  localparam logic [RUN_W-1:0] RUN_ARM = RUN_W'(FILT_TQ - 1);

  logic             rx_q;
  logic [RUN_W-1:0] run_q;
  logic             hit_q;
  logic             pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_q <= 1'b1;
    else        rx_q <= rx;
  end

  assign raw_fall  = rx_q & ~rx;
  assign filt_edge = active & tq_tick & ~rx & (run_q == RUN_ARM);

  // length of the current dominant run in quanta, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                run_q <= '0;
    else if (clear || !active) run_q <= '0;
    else if (tq_tick) begin
      if (rx)                  run_q <= '0;
      else if (run_q != RUN_MAX) run_q <= run_q + 1'b1;
    end
  end

  // confirmed dominant run seen since the last sample point
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                hit_q <= 1'b0;
    else if (clear || !active) hit_q <= 1'b0;
    else if (sp_tick)          hit_q <= 1'b0;
    else if (filt_edge)        hit_q <= 1'b1;
  end

  // raw falling edge inside the current quantum
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pend_q <= 1'b0;
    else if (clear || !active) pend_q <= 1'b0;
    else if (raw_fall)         pend_q <= 1'b1;
    else if (tq_tick)          pend_q <= 1'b0;
  end

  assign dom_hit   = hit_q | filt_edge;
  assign edge_pend = pend_q | raw_fall;
endmodule

// File: rtl/canint_bit_counter.sv
module canint_bit_counter #(
  parameter int IDLE_BITS = 11,
  parameter int CNT_W     = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  input  logic bit_dom,
  output logic finish
);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(IDLE_BITS - 1);
  localparam logic [CNT_W-1:0] CNT_TOP  = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clear) cnt_q <= '0;
    else if (run) begin
      if (bit_dom)              cnt_q <= '0;
      else if (cnt_q != CNT_TOP) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign finish = run && !bit_dom && (cnt_q == CNT_LAST);
endmodule

// File: rtl/canbus_idle_integrator.sv
module canbus_idle_integrator
  import canint_pkg::*;
#(
  parameter int IDLE_BITS = 11,
  parameter int FILT_TQ   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_line,
  input  logic tq_tick,
  input  logic sp_tick,
  input  logic init_ctl,
  input  logic pex_pulse,
  input  logic pex_dis,
  input  logic efilt_en,
  output logic integrating,
  output logic integ_done,
  output logic bus_idle,
  output logic sof_edge
);
  localparam int CNT_W = $clog2(IDLE_BITS + 1);

  phase_e phase_q;
  logic   flt_on_q;
  logic   done_q;
  logic   sof_q;
  logic   sof_d;

  logic enter, abort, clear;
  logic flt_active;
  logic raw_fall, dom_hit, filt_edge, edge_pend;
  logic run, bit_dom, finish;

  canint_entry u_entry (
    .clk      (clk),
    .rst_n    (rst_n),
    .init_ctl (init_ctl),
    .pex_pulse(pex_pulse),
    .pex_dis  (pex_dis),
    .enter    (enter),
    .abort    (abort)
  );

  assign clear      = enter | abort;
  assign flt_active = (phase_q == PH_INTEG) && flt_on_q;

  canint_edge_filter #(.FILT_TQ(FILT_TQ)) u_filt (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (flt_active),
    .clear    (clear),
    .rx       (rx_line),
    .tq_tick  (tq_tick),
    .sp_tick  (sp_tick),
    .raw_fall (raw_fall),
    .dom_hit  (dom_hit),
    .filt_edge(filt_edge),
    .edge_pend(edge_pend)
  );

  assign run     = (phase_q == PH_INTEG) && sp_tick && !clear;
  assign bit_dom = flt_active ? dom_hit : !rx_line;

  canint_bit_counter #(.IDLE_BITS(IDLE_BITS), .CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (clear),
    .run    (run),
    .bit_dom(bit_dom),
    .finish (finish)
  );

  always_comb begin
    sof_d = 1'b0;
    if (!clear) begin
      if (flt_active)           sof_d = filt_edge | (finish & edge_pend);
      else if (phase_q != PH_OFF) sof_d = raw_fall;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_OFF;
      flt_on_q <= 1'b0;
      done_q   <= 1'b0;
      sof_q    <= 1'b0;
    end else begin
      phase_q <= phase_step(phase_q, abort, enter, finish);
      if (abort)      flt_on_q <= 1'b0;
      else if (enter) flt_on_q <= efilt_en;
      done_q <= finish && !clear;
      sof_q  <= sof_d;
    end
  end

  assign integrating = (phase_q == PH_INTEG);
  assign bus_idle    = (phase_q == PH_IDLE);
  assign integ_done  = done_q;
  assign sof_edge    = sof_q;
endmodule

// File: rtl/canint_chk.sv
module canint_chk (
  input logic clk,
  input logic rst_n,
  input logic init_ctl,
  input logic pex_pulse,
  input logic pex_dis,
  input logic integrating,
  input logic integ_done,
  input logic bus_idle,
  input logic sof_edge
);
  // R5
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    integ_done |=> !integ_done);

  // R5
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    integ_done |-> (bus_idle && !integrating));

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_idle && !init_ctl && !(pex_pulse && !pex_dis)) |=> bus_idle);

  // R5
  phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(integrating && bus_idle));

  // R4
  abort_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_ctl |=> (!integrating && !bus_idle && !integ_done && !sof_edge));

  // R2
  init_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(init_ctl) |=> integrating);

  // R3
  pex_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pex_pulse && !pex_dis && !init_ctl) |=> (integrating && !bus_idle));

  // R3
  pex_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pex_pulse && pex_dis && !init_ctl && bus_idle) |=> bus_idle);

  // R10
  sof_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sof_edge |-> (integrating || bus_idle));
endmodule

bind canbus_idle_integrator canint_chk u_canint_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .init_ctl   (init_ctl),
  .pex_pulse  (pex_pulse),
  .pex_dis    (pex_dis),
  .integrating(integrating),
  .integ_done (integ_done),
  .bus_idle   (bus_idle),
  .sof_edge   (sof_edge)
);

// File: tb/canbus_idle_integrator_bench.sv
module canbus_idle_integrator_bench;
  localparam int CLK_PERIOD = 10;
  localparam int IDLE       = 11;
  localparam int WD_LIMIT   = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_line = 1'b1;
  logic tq_tick = 1'b0;
  logic sp_tick = 1'b0;
  logic init_ctl = 1'b1;
  logic pex_pulse = 1'b0;
  logic pex_dis = 1'b0;
  logic efilt_en = 1'b0;
  logic integrating, integ_done, bus_idle, sof_edge;

  canbus_idle_integrator u_canbus_idle_integrator (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .tq_tick(tq_tick),
    .sp_tick(sp_tick), .init_ctl(init_ctl), .pex_pulse(pex_pulse),
    .pex_dis(pex_dis), .efilt_en(efilt_en), .integrating(integrating),
    .integ_done(integ_done), .bus_idle(bus_idle), .sof_edge(sof_edge)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, bad = 0;
  int cur_bit = 0, done_cnt = 0, last_done_bit = -1;
  int sof_cnt = 0, sof_at_done = 0, dbl_done = 0;
  logic prev_done = 1'b0;
  int wd_cyc = 0;

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one clock; samples outputs away from the active edge
  task automatic tick();
    @(negedge clk);
    if (integ_done) begin
      done_cnt++;
      last_done_bit = cur_bit;
      if (sof_edge) sof_at_done++;
      if (prev_done) dbl_done++;
    end
    if (sof_edge) sof_cnt++;
    prev_done = integ_done;
  endtask

  task automatic start_run();
    cur_bit = 0; done_cnt = 0; last_done_bit = -1; sof_cnt = 0; sof_at_done = 0;
  endtask

  // four quanta of two clocks; pattern bit q is rx in quantum q; sample point ends quantum 2
  task automatic send_bit(input logic [3:0] pat);
    for (int q = 0; q < 4; q++) begin
      tick();
      rx_line = pat[q]; tq_tick = 1'b1; sp_tick = 1'b0;
      tick();
      tq_tick = 1'b0; sp_tick = (q == 2);
    end
    cur_bit++;
  endtask

  task automatic rec_bits(input int n);
    for (int i = 0; i < n; i++) send_bit(4'b1111);
  endtask

  task automatic enter_init(input logic f);
    init_ctl = 1'b1; efilt_en = f;
    tick(); tick();
    init_ctl = 1'b0;
    tick(); tick();
    start_run();
  endtask

  task automatic pulse_pex();
    pex_pulse = 1'b1; tick(); pex_pulse = 1'b0; tick();
  endtask

  task automatic expect_done(input string tag, input int exp_bit);
    check({tag, " done count"}, done_cnt, 1);
    check({tag, " done bit"}, last_done_bit, exp_bit);
    check({tag, " idle after"}, int'(bus_idle), 1);
    check({tag, " integrating after"}, int'(integrating), 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      wd_cyc++;
      if (wd_cyc > WD_LIMIT) begin
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", wd_cyc, WD_LIMIT);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    // R1 reset state
    tick(); tick();
    check("R1 integrating in reset", int'(integrating), 0);
    check("R1 idle in reset", int'(bus_idle), 0);
    check("R1 done in reset", int'(integ_done), 0);
    check("R1 sof in reset", int'(sof_edge), 0);
    rst_n = 1'b1;
    tick(); tick(); tick();
    check("R1 no entry while init held", int'(integrating), 0);

    // R2 entry via init fall
    enter_init(1'b0);
    check("R2 integrating after init fall", int'(integrating), 1);
    check("R2 idle cleared", int'(bus_idle), 0);

    // R6 R5 sweep: full dominant bit after d recessive bits
    for (int d = 0; d <= IDLE - 1; d++) begin
      enter_init(1'b0);
      rec_bits(d);
      send_bit(4'b0000);
      rec_bits(IDLE + 1);
      expect_done($sformatf("R6 dom bit at %0d", d), d + IDLE);
      check($sformatf("R10 raw sof nofilt d=%0d", d), sof_cnt, 1);
    end

    // R6 sweep of a single dominant quantum in bit 5, filter off
    for (int qd = 0; qd < 4; qd++) begin
      logic [3:0] pat;
      pat = 4'b1111; pat[qd] = 1'b0;
      enter_init(1'b0);
      rec_bits(5);
      send_bit(pat);
      rec_bits(IDLE + 2);
      expect_done($sformatf("R6 spike q%0d nofilt", qd), (qd == 2) ? 5 + IDLE : IDLE - 1);
      check($sformatf("R10 spike sof q%0d", qd), sof_cnt, 1);
    end

    // R7 single dominant quantum with filter on: ignored wherever it falls
    for (int qd = 0; qd < 4; qd++) begin
      logic [3:0] pat;
      pat = 4'b1111; pat[qd] = 1'b0;
      enter_init(1'b1);
      rec_bits(5);
      send_bit(pat);
      rec_bits(IDLE);
      expect_done($sformatf("R7 spike q%0d filt", qd), IDLE - 1);
      check($sformatf("R10 filtered spike no sof q%0d", qd), sof_cnt, 0);
    end

    // R7 R10 dominant runs of 1..3 quanta from quantum 0 of bit 5
    for (int len = 1; len <= 3; len++) begin
      logic [3:0] pat;
      pat = 4'b1111;
      for (int k = 0; k < len; k++) pat[k] = 1'b0;
      enter_init(1'b1);
      rec_bits(5);
      send_bit(pat);
      rec_bits(IDLE + 1);
      expect_done($sformatf("R7 run len %0d", len), (len >= 2) ? 5 + IDLE : IDLE - 1);
      check($sformatf("R10 filtered sof len %0d", len), sof_cnt, (len >= 2) ? 1 : 0);
    end

    // R7 run straddling a bit boundary, filter on then off
    enter_init(1'b1);
    rec_bits(4); send_bit(4'b0111); send_bit(4'b1110); rec_bits(IDLE + 1);
    expect_done("R7 straddle filt", 5 + IDLE);
    enter_init(1'b0);
    rec_bits(4); send_bit(4'b0111); send_bit(4'b1110); rec_bits(IDLE);
    expect_done("R6 straddle nofilt", IDLE - 1);

    // R11 edge in final quantum with filter on
    enter_init(1'b1);
    rec_bits(IDLE - 1);
    send_bit(4'b1011);
    expect_done("R11 final quantum", IDLE - 1);
    check("R11 sof with done", sof_at_done, 1);
    check("R11 sof count", sof_cnt, 1);
    // R9 filter off once idle: raw edge reported
    rec_bits(1);
    send_bit(4'b1110);
    check("R9 raw sof in idle", sof_cnt, 2);
    check("R5 idle held", int'(bus_idle), 1);
    check("R5 no extra done", done_cnt, 1);

    // R11 contrast: filter off, same edge restarts the count
    enter_init(1'b0);
    rec_bits(IDLE - 1);
    send_bit(4'b1011);
    rec_bits(IDLE + 1);
    expect_done("R11 nofilt contrast", 2 * IDLE - 1);

    // R8 enable latched at entry
    enter_init(1'b1);
    efilt_en = 1'b0;
    rec_bits(5); send_bit(4'b1011); rec_bits(IDLE);
    expect_done("R8 latched on", IDLE - 1);
    enter_init(1'b0);
    efilt_en = 1'b1;
    rec_bits(5); send_bit(4'b1011); rec_bits(IDLE + 1);
    expect_done("R8 latched off", 5 + IDLE);
    efilt_en = 1'b0;

    // R4 abort during integration and from idle
    enter_init(1'b0);
    rec_bits(5);
    init_ctl = 1'b1; tick(); tick();
    check("R4 abort integrating", int'(integrating), 0);
    check("R4 abort idle", int'(bus_idle), 0);
    init_ctl = 1'b0; tick(); tick();
    start_run();
    rec_bits(IDLE + 1);
    expect_done("R4 count restarted", IDLE - 1);
    init_ctl = 1'b1; tick(); tick();
    check("R4 idle cleared by init", int'(bus_idle), 0);
    check("R4 integrating stays low", int'(integrating), 0);
    init_ctl = 1'b0; tick(); tick();
    start_run();
    rec_bits(IDLE);

    // R3 exception pulse, blocked and allowed
    pex_dis = 1'b1; pulse_pex();
    check("R3 blocked keeps idle", int'(bus_idle), 1);
    check("R3 blocked no entry", int'(integrating), 0);
    pex_dis = 1'b0; pulse_pex();
    check("R3 entry from idle", int'(integrating), 1);
    check("R3 idle cleared", int'(bus_idle), 0);
    start_run();
    rec_bits(6);
    pulse_pex();
    start_run();
    rec_bits(IDLE + 1);
    expect_done("R3 restart mid integration", IDLE - 1);

    // R1 reset mid integration
    enter_init(1'b1);
    rec_bits(3);
    rst_n = 1'b0; tick();
    check("R1 reset clears integrating", int'(integrating), 0);
    check("R1 reset clears idle", int'(bus_idle), 0);
    rst_n = 1'b1; tick();

    check("R5 done never two clocks", dbl_done, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule